// File: doc/BRIEF.md
# Half to Single Precision Widener

This block turns a 16-bit IEEE half-precision word into a 32-bit single-precision word. It does not go through any rounding or arithmetic. It takes the sign, exponent and fraction apart and puts them back together at the wider layout. Every finite value comes out numerically identical.

Infinities and NaNs keep their fraction bit for bit. A signalling NaN therefore stays signalling, so a later fused multiply-add stage can still pick the correct NaN operand. The block never reports an exception.

A flush control selects how half-precision subnormals are treated. When it is clear, a subnormal is normalised into an ordinary single-precision number. When it is set, a subnormal becomes a zero that keeps its sign. The result is registered, so it appears one clock after its input strobe.

Top module: `h2s_widen`

## Requirements
- R1: A normal input (exponent field bits 14..10 in 1..30) gives an output exponent (bits 30..23) equal to the input exponent plus 112. The input fraction (bits 9..0) lands in output bits 22..13, and output bits 12..0 are zero.
- R2: An input exponent of all ones gives an output exponent of 0xFF. The 10-bit fraction is carried unchanged into bits 22..13. An input with bit 9 clear and a nonzero fraction (a signalling NaN) therefore yields output bit 22 clear with the payload intact.
- R3: An input with a zero exponent and a zero fraction gives a zero of the same sign (output bits 30..0 all zero).
- R4: With flush clear, a subnormal input (zero exponent, nonzero fraction) is normalised. With k the count of leading zeros of the 10-bit fraction, the output exponent is 112 − k. The fraction is shifted left by k+1, its bits 9..0 go into output bits 22..13, and bits 12..0 are zero.
- R5: With flush set, a subnormal input gives a zero of the same sign. Flush has no effect on inputs of any other class.
- R6: Output bit 31 always equals input bit 15 of the accepted word.
- R7: out_valid_o is high in exactly the cycle after a cycle in which in_valid_i was high.
- R8: In a cycle with in_valid_i low, out_single_o holds its previous value on the next clock.
- R9: While rst_ni is low, out_valid_o and out_single_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word strobe |
| in_half_i | input | 16 | Half-precision operand |
| flush_en_i | input | 1 | Flush half-precision subnormals to signed zero |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| out_single_o | output | 32 | Registered single-precision result |

## Verification
The bench sweeps all 65536 codes under both flush settings. Each code is compared against a shift-until-normalised model, so every subnormal shift amount and every NaN payload is covered. An off-by-one in the leading-zero count would produce results with exponents out by one and a mangled fraction. A converter that quiets NaNs would set bit 22 on signalling inputs, which the dedicated payload check reports. Idle gaps between batches of codes catch two further faults: an output register that loads without the strobe, and a strobe that is pipelined wrongly. Both ends of the subnormal range (fractions 0x001 and 0x3FF) and flushing of negative subnormals are also probed directly.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HEXP_W   = 5;
  localparam int HFRAC_W  = 10;
  localparam int SEXP_W   = 8;
  localparam int SFRAC_W  = 23;
  localparam int HBIAS    = 15;
  localparam int SBIAS    = 127;
  localparam int HALF_W   = 1 + HEXP_W + HFRAC_W;
  localparam int SINGLE_W = 1 + SEXP_W + SFRAC_W;
  localparam int PAD_W    = SFRAC_W - HFRAC_W;
  localparam int LZ_W     = $clog2(HFRAC_W + 1);
  localparam int BIAS_D   = SBIAS - HBIAS;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_SUB  = 2'd1,
    CLS_NORM = 2'd2,
    CLS_SPEC = 2'd3
  } h2s_cls_e;

  typedef struct packed {
    logic               sign;
    h2s_cls_e           cls;
    logic [HEXP_W-1:0]  exp;
    logic [HFRAC_W-1:0] frac;
  } h2s_fields_t;
endpackage

// File: rtl/h2s_unpack.sv
module h2s_unpack
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  output h2s_fields_t       fld_o
);
  logic [HEXP_W-1:0]  exp_w;
  logic [HFRAC_W-1:0] frac_w;

  assign exp_w  = half_i[HALF_W-2 -: HEXP_W];
  assign frac_w = half_i[HFRAC_W-1:0];

  always_comb begin
    fld_o.sign = half_i[HALF_W-1];
    fld_o.exp  = exp_w;
    fld_o.frac = frac_w;
    if (&exp_w)           fld_o.cls = CLS_SPEC;
    else if (exp_w != '0) fld_o.cls = CLS_NORM;
    else if (frac_w != '0) fld_o.cls = CLS_SUB;
    else                  fld_o.cls = CLS_ZERO;
  end
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W     = 10,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  // ascending scan: the highest set bit is written last and wins
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/h2s_repack.sv
module h2s_repack
  import h2s_pkg::*;
(
  input  h2s_fields_t         fld_i,
  input  logic [LZ_W-1:0]     lz_i,
  input  logic                flush_i,
  output logic [SINGLE_W-1:0] single_o
);
  logic [LZ_W-1:0]      shamt;
  logic [2*HFRAC_W-1:0] shifted;
  logic [HFRAC_W-1:0]   sub_frac;
  logic [SEXP_W-1:0]    sub_exp;
  logic [SEXP_W-1:0]    norm_exp;

  assign shamt    = lz_i + LZ_W'(1);
  assign shifted  = {{HFRAC_W{1'b0}}, fld_i.frac} << shamt;
  assign sub_frac = shifted[HFRAC_W-1:0];
  assign sub_exp  = SEXP_W'(BIAS_D) - SEXP_W'(lz_i);
  assign norm_exp = SEXP_W'(fld_i.exp) + SEXP_W'(BIAS_D);

  always_comb begin
    unique case (fld_i.cls)
      CLS_SPEC: single_o = {fld_i.sign, {SEXP_W{1'b1}}, fld_i.frac, {PAD_W{1'b0}}};
      CLS_NORM: single_o = {fld_i.sign, norm_exp, fld_i.frac, {PAD_W{1'b0}}};
      CLS_SUB: begin
        if (flush_i) single_o = {fld_i.sign, {(SINGLE_W-1){1'b0}}};
        else         single_o = {fld_i.sign, sub_exp, sub_frac, {PAD_W{1'b0}}};
      end
      default:  single_o = {fld_i.sign, {(SINGLE_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [HALF_W-1:0]   in_half_i,
  input  logic                flush_en_i,
  output logic                out_valid_o,
  output logic [SINGLE_W-1:0] out_single_o
);
  h2s_fields_t         fld;
  logic [LZ_W-1:0]     lz;
  logic [SINGLE_W-1:0] packed_d;

  h2s_unpack u_unpack (
    .half_i (in_half_i),
    .fld_o  (fld)
  );

  h2s_lzc #(.W(HFRAC_W), .CNT_W(LZ_W)) u_lzc (
    .vec_i (fld.frac),
    .cnt_o (lz)
  );

  h2s_repack u_repack (
    .fld_i    (fld),
    .lz_i     (lz),
    .flush_i  (flush_en_i),
    .single_o (packed_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_single_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_single_o <= packed_d;
    end
  end
endmodule

// File: rtl/h2s_widen_chk.sv
module h2s_widen_chk
  import h2s_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic [HALF_W-1:0]   in_half_i,
  input logic                flush_en_i,
  input logic                out_valid_o,
  input logic [SINGLE_W-1:0] out_single_o
);
  // R9
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!out_valid_o && out_single_o == '0);
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R7
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R8
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_single_o));

  // R6
  sign_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_single_o[SINGLE_W-1] == $past(in_half_i[HALF_W-1]));

  // R2
  spec_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (&in_half_i[HALF_W-2 -: HEXP_W])) |=>
      ((&out_single_o[SINGLE_W-2 -: SEXP_W]) &&
       out_single_o[SFRAC_W-1 -: HFRAC_W] == $past(in_half_i[HFRAC_W-1:0])));

  // R5
  flush_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && flush_en_i && in_half_i[HALF_W-2 -: HEXP_W] == '0) |=>
      out_single_o[SINGLE_W-2:0] == '0);

  // R1
  low_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_single_o[PAD_W-1:0] == '0);

  // R4
  sub_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !flush_en_i && in_half_i[HALF_W-2 -: HEXP_W] == '0 &&
     in_half_i[HFRAC_W-1:0] != '0) |=>
      (out_single_o[SINGLE_W-2 -: SEXP_W] <= SEXP_W'(BIAS_D) &&
       out_single_o[SINGLE_W-2 -: SEXP_W] >  SEXP_W'(BIAS_D - HFRAC_W)));
endmodule

bind h2s_widen h2s_widen_chk u_chk (.*);

// File: tb/tb_h2s_widen.sv
`timescale 1ns/1ps
module tb_h2s_widen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_half_i = '0;
  logic        flush_en_i = 1'b0;
  logic        out_valid_o;
  logic [31:0] out_single_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic        exp_v = 1'b0;
  logic [31:0] exp_d = '0;
  logic [15:0] exp_h = '0;
  string       exp_tag = "R9";

  always #2.5 clk_i = ~clk_i;

  h2s_widen dut (.*);

  function automatic logic [31:0] ref_conv(logic [15:0] h, logic f);
    logic [10:0] mm;
    int k;
    if (h[14:10] == 5'h1f) return {h[15], 8'hff, h[9:0], 13'b0};
    if (h[14:10] != 5'h00) return {h[15], 8'(int'(h[14:10]) + 112), h[9:0], 13'b0};
    if (h[9:0] == 10'd0 || f) return {h[15], 31'b0};
    mm = {1'b0, h[9:0]};
    k = 0;
    while (!mm[10]) begin mm = mm << 1; k++; end
    return {h[15], 8'(113 - k), mm[9:0], 13'b0};
  endfunction

  function automatic string tag_of(logic [15:0] h, logic f);
    if (h[14:10] == 5'h1f) return "R2";
    if (h[14:10] != 5'h00) return f ? "R5" : "R1";
    if (h[9:0] == 10'd0)   return "R3";
    return f ? "R5" : "R4";
  endfunction

  task automatic compare();
    total++;
    if (out_valid_o !== exp_v) begin
      bad++;
      $display("FAIL R7 valid act=%0b exp=%0b", out_valid_o, exp_v);
    end
    total++;
    if (out_single_o !== exp_d) begin
      bad++;
      $display("FAIL %s in=%h act=%h exp=%h", exp_tag, exp_h, out_single_o, exp_d);
    end
    // R6 sign, separately reported
    total++;
    if (exp_v && out_single_o[31] !== exp_h[15]) begin
      bad++;
      $display("FAIL R6 in=%h act=%b exp=%b", exp_h, out_single_o[31], exp_h[15]);
    end
    if (exp_v && exp_h[14:10] == 5'h1f && !exp_h[9] && exp_h[8:0] != 9'd0) begin
      total++;
      if (out_single_o[22] !== 1'b0 || out_single_o[21:13] !== exp_h[8:0]) begin
        bad++;
        $display("FAIL R2 snan in=%h act=%h exp=%h", exp_h, out_single_o[22:13], {1'b0, exp_h[8:0]});
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] h, input logic f, input string tag);
    @(negedge clk_i);
    compare();
    in_valid_i = v;
    in_half_i  = h;
    flush_en_i = f;
    if (v) begin
      exp_v = 1'b1; exp_d = ref_conv(h, f); exp_h = h; exp_tag = tag;
    end else begin
      exp_v = 1'b0; exp_tag = "R8";
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R9 while reset is held
    total++;
    if (out_valid_o !== 1'b0 || out_single_o !== 32'h0) begin
      bad++;
      $display("FAIL R9 act=%b/%h exp=0/00000000", out_valid_o, out_single_o);
    end
    rst_ni = 1'b1;
    // directed corners
    step(1'b1, 16'h3c00, 1'b0, "R1");
    step(1'b1, 16'h7c01, 1'b0, "R2");
    step(1'b1, 16'hfe55, 1'b1, "R2");
    step(1'b1, 16'h8000, 1'b0, "R3");
    step(1'b1, 16'h0001, 1'b0, "R4");
    step(1'b1, 16'h03ff, 1'b0, "R4");
    step(1'b1, 16'h8001, 1'b1, "R5");
    step(1'b1, 16'h0400, 1'b1, "R5");
    step(1'b0, 16'h1234, 1'b0, "R8");
    step(1'b0, 16'h0000, 1'b1, "R8");
    // full sweep, both flush settings
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 65536; c++) begin
        step(1'b1, 16'(c), 1'(f), tag_of(16'(c), 1'(f)));
        if ((c % 4096) == 4095) step(1'b0, 16'(~c), 1'(~f), "R8");
      end
    end
    step(1'b0, 16'h0, 1'b0, "R8");
    step(1'b0, 16'h0, 1'b0, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule